// File: doc/BRIEF.md
# Gain Envelope Generator

This block keeps a 6-bit gain level and moves it by one step, up or down, every time an internal timer runs out. The timer period in clock cycles is 8 × (envelope speed + 1) × (master speed + 1). The envelope speed is 6 bits and comes from the block's own control byte. The master speed is 8 bits and is shared with other envelopes. One clock cycle equals one CPU cycle.

Software programs the envelope through a single control byte. Bit 7 selects direct mode: the envelope is off and the gain is loaded at once. Bit 6 selects the ramp direction, with 1 meaning up. Bits 5..0 hold the speed, and in direct mode they also hold the gain.

Three chip-level controls can stop the ramp:
- an envelope-disable line, which also restarts the timer;
- a wave-halt line, which freezes the timer where it is;
- a speed-up line, which makes the period four times shorter.

The gain is available as a raw 6-bit value and as a read byte. A one-cycle strobe marks each timer expiry.

Top module: `gain_ramp_env`

## Requirements
- R1: After synchronous reset the gain, the stored speed and the timer are zero, `tick` is low and `gain_rd` reads 0x40.
- R2: A control write whose bit 7 is 1 loads bits 5..0 (0 to 63) into the gain, visible the cycle after the write. When bit 7 is 0 the gain is not loaded and keeps its value. Bit 6 stores the direction (1 up, 0 down), and bit 7 stores the mode.
- R3: Every control write stores bits 5..0 as the speed s. While running, `tick` pulses high for one cycle P = 8*(s+1)*(m+1) clock cycles after the write is sampled. Here m is `master_speed`. The gain step lands on the same edge as the pulse. If the period shrinks below the cycles already counted, the timer expires on the next running cycle.
- R4: In up mode a tick adds 1 only while the gain is below 32. A gain of 32 or more never rises.
- R5: In down mode a tick subtracts 1 only while the gain is above 0, and this includes values above 32. The gain holds at 0.
- R6: A control write restarts the timer. A write that coincides with an expiry suppresses that tick.
- R7: While `master_speed` is 0 no tick occurs, and the timer restarts.
- R8: While `env_disable` is high no tick occurs and the timer is cleared. The first tick comes P cycles after the last cycle in which it was high.
- R9: While `wave_halt` is high no tick occurs and the timer holds its count. Halting for H cycles delays the next tick by H cycles.
- R10: With `speed_x4` high the period is 2*(s+1)*(m+1) cycles.
- R11: In direct mode the timer keeps running and `tick` still pulses, but ticks leave the gain unchanged.
- R12: `gain_rd` always equals {2'b01, gain}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CPU cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control byte: [7] direct mode, [6] up, [5:0] speed/gain |
| master_speed | input | 8 | Shared master speed; 0 stops ticking |
| env_disable | input | 1 | Stops ticking and clears the timer |
| speed_x4 | input | 1 | Shortens the period by a factor of four |
| wave_halt | input | 1 | Stops ticking and freezes the timer |
| gain | output | 6 | Current gain level |
| gain_rd | output | 8 | Read byte: 01 in bits 7..6, gain below |
| tick | output | 1 | One-cycle strobe at each timer expiry |

## Verification
A control write shows up in the gain one cycle after the edge that samples it. Timer expiries are due exactly P running cycles after that edge. Frozen cycles from `wave_halt` are added on top, and a disable or a zero master speed starts the count again from its last active cycle.

The bench keeps a cycle model that is advanced on every rising edge from the inputs held since the previous falling edge. `gain` and `tick` are compared with that model at every falling edge. Period checks count the falling edges from the write, or from the release, up to the first `tick`, and compare the count with the formula.

// File: rtl/gain_env_pkg.sv
package gain_env_pkg;

    localparam int unsigned GAIN_W   = 6;
    localparam int unsigned MSPD_W   = 8;
    localparam int unsigned CTRL_W   = GAIN_W + 2;
    localparam int unsigned DIV_SLOW = 8;
    localparam int unsigned DIV_FAST = 2;
    localparam int unsigned GAIN_CAP = 32;
    localparam int unsigned TMR_W    = GAIN_W + MSPD_W + $clog2(DIV_SLOW);

    typedef logic [GAIN_W-1:0] gain_t;
    typedef logic [MSPD_W-1:0] mspd_t;
    typedef logic [TMR_W-1:0]  tcount_t;

    // control byte as seen by the ramp
    typedef struct packed {
        logic  direct;   // 1: envelope off, value loaded as gain
        logic  rise;     // 1: ramp up, 0: ramp down
        gain_t val;      // speed, and gain when direct
    } env_ctrl_t;

    typedef enum logic [1:0] {
        TMR_RESTART = 2'd0,
        TMR_FREEZE  = 2'd1,
        TMR_RUN     = 2'd2
    } tmr_mode_e;

    // last count value of a period: div*(spd+1)*(mst+1) - 1
    function automatic tcount_t period_last(gain_t spd, mspd_t mst, logic fast);
        int unsigned p;
        p = (32'(spd) + 32'd1) * (32'(mst) + 32'd1) * (fast ? DIV_FAST : DIV_SLOW);
        return TMR_W'(p - 32'd1);
    endfunction

    // one ramp step with saturation
    function automatic gain_t ramp_step(gain_t g, logic rise);
        if (rise)
            return (g < gain_t'(GAIN_CAP)) ? g + gain_t'(1) : g;
        else
            return (g != '0) ? g - gain_t'(1) : g;
    endfunction

endpackage

// File: rtl/env_timer.sv
module env_timer
    import gain_env_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tmr_mode_e mode,
    input  tcount_t   last,
    output logic      expire
);

    tcount_t count_q;

    // >= keeps the counter bounded when the period shrinks mid-count
    assign expire = (mode == TMR_RUN) && (count_q >= last);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            case (mode)
                TMR_RESTART: count_q <= '0;
                TMR_FREEZE:  count_q <= count_q;
                TMR_RUN:     count_q <= expire ? '0 : count_q + tcount_t'(1);
                default:     count_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/env_ramp.sv
module env_ramp
    import gain_env_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  env_ctrl_t ctrl_in,
    input  logic      step,
    output gain_t     gain,
    output gain_t     speed
);

    env_ctrl_t cfg_q;
    gain_t     gain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            gain_q <= '0;
        end else if (load) begin
            cfg_q <= ctrl_in;
            if (ctrl_in.direct)
                gain_q <= ctrl_in.val;
        end else if (step && !cfg_q.direct) begin
            gain_q <= ramp_step(gain_q, cfg_q.rise);
        end
    end

    assign gain  = gain_q;
    assign speed = cfg_q.val;

endmodule

// File: rtl/gain_ramp_env.sv
module gain_ramp_env
    import gain_env_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [MSPD_W-1:0] master_speed,
    input  logic              env_disable,
    input  logic              speed_x4,
    input  logic              wave_halt,
    output logic [GAIN_W-1:0] gain,
    output logic [CTRL_W-1:0] gain_rd,
    output logic              tick
);

    tmr_mode_e tmr_mode;
    tcount_t   tmr_last;
    logic      expire;
    gain_t     speed;
    gain_t     gain_w;
    logic      tick_q;

    // restart has priority over freeze
    always_comb begin
        if (wr_en || env_disable || (master_speed == '0))
            tmr_mode = TMR_RESTART;
        else if (wave_halt)
            tmr_mode = TMR_FREEZE;
        else
            tmr_mode = TMR_RUN;
    end

    assign tmr_last = period_last(speed, master_speed, speed_x4);

    env_timer i_timer (
        .clk    (clk),
        .rst    (rst),
        .mode   (tmr_mode),
        .last   (tmr_last),
        .expire (expire)
    );

    env_ramp i_ramp (
        .clk     (clk),
        .rst     (rst),
        .load    (wr_en),
        .ctrl_in (env_ctrl_t'(wr_data)),
        .step    (expire),
        .gain    (gain_w),
        .speed   (speed)
    );

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= expire;
    end

    assign gain    = gain_w;
    assign gain_rd = {2'b01, gain_w};
    assign tick    = tick_q;

endmodule

// File: rtl/gain_env_chk.sv
module gain_env_chk
    import gain_env_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic [MSPD_W-1:0] master_speed,
    input logic              env_disable,
    input logic              wave_halt,
    input logic [GAIN_W-1:0] gain,
    input logic              tick
);

    logic seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    assert_direct_load_R2: assert property (@(posedge clk) disable iff (rst)
        seen && $past(wr_en) && $past(wr_data[CTRL_W-1]) |-> gain == $past(wr_data[GAIN_W-1:0]));

    assert_gain_moves_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        seen && !$past(wr_en) && !tick |-> gain == $past(gain));

    assert_no_rise_at_cap_R4: assert property (@(posedge clk) disable iff (rst)
        seen && !$past(wr_en) && ($past(gain) >= gain_t'(GAIN_CAP)) |-> gain <= $past(gain));

    assert_write_kills_tick_R6: assert property (@(posedge clk) disable iff (rst)
        seen && $past(wr_en) |-> !tick);

    assert_master_zero_R7: assert property (@(posedge clk) disable iff (rst)
        seen && ($past(master_speed) == '0) |-> !tick);

    assert_disable_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        seen && $past(env_disable) |-> !tick);

    assert_halt_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        seen && $past(wave_halt) |-> !tick);

endmodule

bind gain_ramp_env gain_env_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .master_speed (master_speed),
    .env_disable  (env_disable),
    .wave_halt    (wave_halt),
    .gain         (gain),
    .tick         (tick)
);

// File: tb/test_gain_ramp_env.sv
`timescale 1ns/1ps
module test_gain_ramp_env;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] master_speed = 8'd1;
    logic       env_disable = 1'b0;
    logic       speed_x4 = 1'b0;
    logic       wave_halt = 1'b0;
    logic [5:0] gain;
    logic [7:0] gain_rd;
    logic       tick;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    int m_gain = 0, m_speed = 0, m_el = 0;
    bit m_direct = 0, m_rise = 0, m_tick = 0;

    always #4 clk = ~clk;   // 125 MHz

    gain_ramp_env i_gain_ramp_env (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .master_speed(master_speed), .env_disable(env_disable),
        .speed_x4(speed_x4), .wave_halt(wave_halt),
        .gain(gain), .gain_rd(gain_rd), .tick(tick)
    );

    function automatic int exp_period(int s, int m, bit fast);
        return (fast ? 2 : 8) * (s + 1) * (m + 1);
    endfunction

    function automatic int exp_step(int g, bit up);
        if (up) return (g < 32) ? g + 1 : g;
        return (g > 0) ? g - 1 : g;
    endfunction

    task automatic check(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one clock: update model at the edge, compare at the falling edge
    task automatic step(string tag);
        @(posedge clk);
        if (rst) begin
            m_gain = 0; m_speed = 0; m_el = 0;
            m_direct = 0; m_rise = 0; m_tick = 0;
        end else if (wr_en) begin
            m_speed = wr_data[5:0]; m_direct = wr_data[7]; m_rise = wr_data[6];
            if (m_direct) m_gain = wr_data[5:0];
            m_el = 0; m_tick = 0;
        end else if (env_disable || master_speed == 0) begin
            m_el = 0; m_tick = 0;
        end else if (wave_halt) begin
            m_tick = 0;
        end else if (m_el + 1 >= exp_period(m_speed, master_speed, speed_x4)) begin
            m_tick = 1; m_el = 0;
            if (!m_direct) m_gain = exp_step(m_gain, m_rise);
        end else begin
            m_el++; m_tick = 0;
        end
        @(negedge clk);
        check(gain, m_gain, {tag, " gain"});
        check(tick, m_tick, {tag, " tick"});
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic write(logic [7:0] d, string tag);
        wr_en = 1'b1; wr_data = d;
        step(tag);
        wr_en = 1'b0;
    endtask

    // falling edges until the first tick
    task automatic cycles_to_tick(string tag, output int n);
        n = 0;
        do begin
            step(tag);
            n++;
        end while (!tick && n < 5000);
    endtask

    initial begin
        int n;
        int ticks;
        void'($urandom(32'd2024));
        @(negedge clk);
        run(3, "R1 reset");
        rst = 1'b0;
        run(1, "R1");
        check(gain, 0, "R1 gain");
        check(gain_rd, 8'h40, "R1 gain_rd");
        check(tick, 0, "R1 tick");

        write(8'hBF, "R2 direct");
        check(gain, 63, "R2 load 63");
        check(gain_rd, 8'h7F, "R12 read byte");
        write(8'h00, "R2 no load");
        check(gain, 63, "R2 gain kept");

        run(1100, "R5 ramp down");
        check(gain, 0, "R5 floor");

        write(8'h02, "R3");
        cycles_to_tick("R3", n);
        check(n, 48, "R3 period");

        speed_x4 = 1'b1;
        write(8'h02, "R10");
        cycles_to_tick("R10", n);
        check(n, 12, "R10 fast period");
        speed_x4 = 1'b0;

        write(8'h9E, "R4 set 30");
        write(8'h40, "R4 up");
        run(200, "R4 ramp up");
        check(gain, 32, "R4 cap");
        write(8'hA8, "R4 set 40");
        write(8'h40, "R4 up");
        run(100, "R4 above cap");
        check(gain, 40, "R4 no rise");

        write(8'h40, "R6");
        run(10, "R6");
        write(8'h40, "R6 rewrite");
        cycles_to_tick("R6", n);
        check(n, 16, "R6 restart");

        env_disable = 1'b1;
        run(30, "R8 disabled");
        env_disable = 1'b0;
        cycles_to_tick("R8", n);
        check(n, 16, "R8 after release");

        write(8'h40, "R9");
        run(5, "R9");
        wave_halt = 1'b1;
        run(20, "R9 halted");
        wave_halt = 1'b0;
        cycles_to_tick("R9", n);
        check(n, 11, "R9 frozen timer");

        master_speed = 8'd0;
        ticks = 0;
        for (int i = 0; i < 200; i++) begin
            step("R7");
            if (tick) ticks++;
        end
        check(ticks, 0, "R7 no ticks");
        master_speed = 8'd1;

        write(8'h85, "R11");
        cycles_to_tick("R11", n);
        check(n, 96, "R11 period");
        check(gain, 5, "R11 gain held");

        for (int i = 0; i < 4000; i++) begin
            wr_en = ($urandom % 50) == 0;
            if (wr_en) begin
                bit dm;
                dm = ($urandom % 4) == 0;
                wr_data = {dm, 1'($urandom), dm ? 6'($urandom) : 6'($urandom % 4)};
            end
            env_disable = ($urandom % 100) < 2;
            wave_halt   = ($urandom % 100) < 5;
            if (($urandom % 200) == 0) speed_x4 = ~speed_x4;
            if (($urandom % 300) == 0) master_speed = 8'($urandom % 4);
            step("R3 random");
            check(gain_rd, {2'b01, gain}, "R12 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule